// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block is the digital controller that sits around a successive-approximation converter. Software talks to it through a small byte-wide register port: a control/status byte, a select byte for input channel, reference and result format, and two result bytes. The sequencer derives a slow converter clock from the system clock and counts the converter-clock cycles of every conversion. It launches conversions on a software request, back to back in free-running mode, or on a rising edge of an external trigger. It then latches the 10-bit code, raises a completion flag and drives an interrupt request.

The analog front end is not part of the block. The code presented on `sar_code` is taken as the conversion result in the cycle the count expires. Channel and reference choices are shown to the analog side on `chan_o` and `ref_o`. They change only between conversions, so a conversion in flight never sees its input or reference move. The result format bit is the exception: it re-arranges the result bytes at once.

Top module: `adcseq_ctrl`

## Requirements
- R1: Control byte (address 0) bits 2:0 pick the divider from system clock to converter clock: codes 0 and 1 divide by 2, and code k from 2 to 7 divides by 2^k.
- R2: A conversion takes 13 converter-clock cycles. The first conversion started after the enable bit (control bit 3) goes from 0 to 1 takes 25. This includes a conversion started by the same write that sets enable.
- R3: The first conversion after the applied reference value changes takes 25 converter-clock cycles.
- R4: Writing 1 to control bit 4 while enable is written 1 and no conversion runs starts a conversion. Bit 4 reads 1 while a conversion is in progress and 0 otherwise. Writing 0 to it starts nothing and stops nothing.
- R5: With control bit 7 set and select bit 7 at 0 (free-running), each completion immediately starts the next conversion, with no further software start.
- R6: Writing enable to 0 during a conversion ends it at once. The completion flag is not set and the result bytes keep their old value.
- R7: The completion flag (control bit 6) is set in the cycle after a conversion completes, together with the result update. It is cleared by a pulse on `irq_ack` or by writing 1 to bit 6. A completion in the same cycle as a clear wins.
- R8: `irq` is high exactly when the completion flag, the interrupt enable (control bit 5) and `gie` are all 1.
- R9: The select byte (address 1) holds channel in bits 3:0 and reference in bits 5:4. These reach `chan_o`/`ref_o` one cycle after the write when idle. A write made during a conversion reaches them only when that conversion completes.
- R10: Select bit 6 chooses the result layout and acts immediately. At 0 the code sits in bits 9:0 of the 16-bit result pair; at 1 it sits in bits 15:6. The low byte is at address 2 and the high byte at address 3.
- R11: With control bit 7 set and select bit 7 at 1, a rising edge on `trig_in` while enabled and idle starts a conversion at the clock edge that samples the high level.
- R12: A rising edge on `trig_in` while a conversion runs is dropped, not remembered for later.
- R13: While enable is 0 the divider counter is held at zero. After enable and start are written together, a first conversion therefore keeps bit 4 high for exactly 25 times the divide factor system cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address: 0 control, 1 select, 2 result low, 3 result high |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register (combinational) |
| trig_in | input | 1 | External conversion trigger, rising-edge active |
| gie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Interrupt acknowledge, clears the completion flag |
| sar_code | input | 10 | Code from the analog converter, sampled at completion |
| irq | output | 1 | Conversion-complete interrupt request |
| chan_o | output | 4 | Channel select applied to the analog side |
| ref_o | output | 2 | Reference select applied to the analog side |
| busy_o | output | 1 | Conversion in progress |

## Verification
On every cycle the assertions check several invariants. No two divider ticks are adjacent, and the divider stays silent just after a disabled cycle. The cycle counter stays within the long-conversion length while busy, and busy drops one cycle after enable goes low. Every completion is followed by a set flag, and applied selects hold still through a running conversion. The bench scenarios show what a single-cycle property cannot. These are the exact 25- and 13-cycle lengths at several divide factors, and the long conversion after a deferred reference change. They also cover free-running chaining across many conversions, abort leaving flag and result alone, a dropped trigger during a busy period, and the immediate re-layout of a finished result.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
  // register addresses
  localparam logic [1:0] ADDR_CTL   = 2'd0;
  localparam logic [1:0] ADDR_SEL   = 2'd1;
  localparam logic [1:0] ADDR_RES_L = 2'd2;
  localparam logic [1:0] ADDR_RES_H = 2'd3;

  // control byte fields
  localparam int CTL_DIV_LSB = 0;
  localparam int CTL_EN      = 3;
  localparam int CTL_GO      = 4;
  localparam int CTL_IE      = 5;
  localparam int CTL_FLAG    = 6;
  localparam int CTL_AUTO    = 7;

  // select byte fields
  localparam int SEL_CHAN_LSB = 0;
  localparam int SEL_REF_LSB  = 4;
  localparam int SEL_LADJ     = 6;
  localparam int SEL_SRC      = 7;

  // start source of automatic conversions
  typedef enum logic {SRC_FREE = 1'b0, SRC_TRIG = 1'b1} auto_src_e;
endpackage

// File: rtl/adcseq_clkdiv.sv
module adcseq_clkdiv #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int PC_W = (1 << SEL_W) - 1;
  localparam int DV_W = PC_W + 1;

  logic [PC_W-1:0] pc_q, pc_nx;
  logic [DV_W-1:0] lim;

  always_comb begin
    if (sel_i < SEL_W'(2)) lim = DV_W'(1);
    else                   lim = (DV_W'(1) << sel_i) - DV_W'(1);
  end

  assign tick_o = en_i && ({1'b0, pc_q} >= lim);

  always_comb begin
    if (!en_i)       pc_nx = '0;
    else if (tick_o) pc_nx = '0;
    else             pc_nx = pc_q + PC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_nx;
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o); // R1
  AST_DIV_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !tick_o); // R13
endmodule

// File: rtl/adcseq_timer.sv
module adcseq_timer #(
  parameter int SHORT_CYC = 13,
  parameter int LONG_CYC  = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic tick_i,
  input  logic start_i,
  input  logic long_i,
  output logic busy_o,
  output logic done_o
);
  localparam int LC_W = $clog2(LONG_CYC + 1);

  logic [LC_W-1:0] left_q, left_nx;
  logic            busy_q, busy_nx;

  assign done_o = busy_q && tick_i && (left_q == LC_W'(1)) && en_i;
  assign busy_o = busy_q;

  always_comb begin
    if (!en_i)       busy_nx = 1'b0;
    else if (start_i) busy_nx = 1'b1;
    else if (done_o) busy_nx = 1'b0;
    else             busy_nx = busy_q;
  end

  always_comb begin
    if (start_i)              left_nx = long_i ? LC_W'(LONG_CYC) : LC_W'(SHORT_CYC);
    else if (busy_q && tick_i) left_nx = left_q - LC_W'(1);
    else                      left_nx = left_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      left_q <= '0;
    end else begin
      busy_q <= busy_nx;
      left_q <= left_nx;
    end
  end

  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (left_q >= LC_W'(1)) && (left_q <= LC_W'(LONG_CYC))); // R2
  AST_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !busy_q); // R6
  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !start_i |=> !busy_q); // R5
endmodule

// File: rtl/adcseq_fmt.sv
module adcseq_fmt #(
  parameter int RES_W = 10,
  parameter int OUT_W = 16
) (
  input  logic [RES_W-1:0] res_i,
  input  logic             left_i,
  output logic [OUT_W-1:0] word_o
);
  localparam int PAD = OUT_W - RES_W;

  generate
    if (PAD == 0) begin : g_full
      assign word_o = res_i;
      logic unused_left;
      assign unused_left = left_i;
    end else begin : g_pad
      assign word_o = left_i ? {res_i, {PAD{1'b0}}} : {{PAD{1'b0}}, res_i};
    end
  endgenerate
endmodule

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
  import adcseq_pkg::*;
#(
  parameter int RES_W     = 10,
  parameter int SHORT_CYC = 13,
  parameter int LONG_CYC  = 25,
  parameter int DIV_SEL_W = 3,
  parameter int CHAN_W    = 4,
  parameter int REF_W     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              trig_in,
  input  logic              gie,
  input  logic              irq_ack,
  input  logic [RES_W-1:0]  sar_code,
  output logic              irq,
  output logic [CHAN_W-1:0] chan_o,
  output logic [REF_W-1:0]  ref_o,
  output logic              busy_o
);
  localparam int OUT_W = 16;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i = rsync_q[1];

  // register state
  logic                 en_q, ie_q, auto_q, flag_q, ladj_q, first_q, long_q, trigd_q;
  auto_src_e            src_q;
  logic [DIV_SEL_W-1:0] div_q;
  logic [CHAN_W-1:0]    pchan_q, achan_q;
  logic [REF_W-1:0]     pref_q, aref_q;
  logic [RES_W-1:0]     res_q;

  // next-state signals
  logic                 en_nx, ie_nx, auto_nx, flag_nx, ladj_nx, first_nx, long_nx;
  auto_src_e            src_nx;
  logic [DIV_SEL_W-1:0] div_nx;
  logic [CHAN_W-1:0]    pchan_nx, achan_nx;
  logic [REF_W-1:0]     pref_nx, aref_nx;
  logic [RES_W-1:0]     res_nx;

  logic wr_ctl, wr_sel, en_rise, trig_edge, load_sel, ref_diff, long_req;
  logic sw_go, hw_go, fr_go, start, tick, busy, done;
  logic [OUT_W-1:0] res_word;

  assign wr_ctl    = bus_wr && (bus_addr == ADDR_CTL);
  assign wr_sel    = bus_wr && (bus_addr == ADDR_SEL);
  assign en_nx     = wr_ctl ? bus_wdata[CTL_EN] : en_q;
  assign en_rise   = wr_ctl && bus_wdata[CTL_EN] && !en_q;
  assign trig_edge = trig_in && !trigd_q;

  // selects reach the analog side only between conversions
  assign load_sel  = !busy || done;
  assign ref_diff  = load_sel && (pref_q != aref_q);
  assign long_req  = first_q || en_rise || long_q || ref_diff;

  assign sw_go = wr_ctl && bus_wdata[CTL_GO] && bus_wdata[CTL_EN];
  assign hw_go = en_q && auto_q && (src_q == SRC_TRIG) && trig_edge;
  assign fr_go = done && auto_q && (src_q == SRC_FREE);
  assign start = (!busy && (sw_go || hw_go)) || fr_go;

  adcseq_clkdiv #(.SEL_W(DIV_SEL_W)) u_div (
    .clk   (clk),
    .rst_n (rst_i),
    .en_i  (en_q),
    .sel_i (div_q),
    .tick_o(tick)
  );

  adcseq_timer #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_i),
    .en_i   (en_nx),
    .tick_i (tick),
    .start_i(start),
    .long_i (long_req),
    .busy_o (busy),
    .done_o (done)
  );

  adcseq_fmt #(.RES_W(RES_W), .OUT_W(OUT_W)) u_fmt (
    .res_i (res_q),
    .left_i(ladj_q),
    .word_o(res_word)
  );

  // next-state logic
  always_comb begin
    ie_nx    = ie_q;
    auto_nx  = auto_q;
    div_nx   = div_q;
    if (wr_ctl) begin
      ie_nx   = bus_wdata[CTL_IE];
      auto_nx = bus_wdata[CTL_AUTO];
      div_nx  = bus_wdata[CTL_DIV_LSB +: DIV_SEL_W];
    end

    src_nx   = src_q;
    ladj_nx  = ladj_q;
    pchan_nx = pchan_q;
    pref_nx  = pref_q;
    if (wr_sel) begin
      src_nx   = auto_src_e'(bus_wdata[SEL_SRC]);
      ladj_nx  = bus_wdata[SEL_LADJ];
      pchan_nx = bus_wdata[SEL_CHAN_LSB +: CHAN_W];
      pref_nx  = bus_wdata[SEL_REF_LSB +: REF_W];
    end

    achan_nx = load_sel ? pchan_q : achan_q;
    aref_nx  = load_sel ? pref_q  : aref_q;

    if (done)                                             flag_nx = 1'b1;
    else if (irq_ack || (wr_ctl && bus_wdata[CTL_FLAG]))  flag_nx = 1'b0;
    else                                                  flag_nx = flag_q;

    res_nx = done ? sar_code : res_q;

    if (!en_nx)       first_nx = 1'b0;
    else if (start)   first_nx = 1'b0;
    else if (en_rise) first_nx = 1'b1;
    else              first_nx = first_q;

    if (start)         long_nx = 1'b0;
    else if (ref_diff) long_nx = 1'b1;
    else               long_nx = long_q;
  end

  // register process
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      en_q    <= 1'b0;
      ie_q    <= 1'b0;
      auto_q  <= 1'b0;
      div_q   <= '0;
      flag_q  <= 1'b0;
      src_q   <= SRC_FREE;
      ladj_q  <= 1'b0;
      pchan_q <= '0;
      pref_q  <= '0;
      achan_q <= '0;
      aref_q  <= '0;
      res_q   <= '0;
      first_q <= 1'b0;
      long_q  <= 1'b0;
      trigd_q <= 1'b0;
    end else begin
      en_q    <= en_nx;
      ie_q    <= ie_nx;
      auto_q  <= auto_nx;
      div_q   <= div_nx;
      flag_q  <= flag_nx;
      src_q   <= src_nx;
      ladj_q  <= ladj_nx;
      pchan_q <= pchan_nx;
      pref_q  <= pref_nx;
      achan_q <= achan_nx;
      aref_q  <= aref_nx;
      if (done) res_q <= res_nx;
      first_q <= first_nx;
      long_q  <= long_nx;
      trigd_q <= trig_in;
    end
  end

  // read side
  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      ADDR_CTL: begin
        bus_rdata[CTL_DIV_LSB +: DIV_SEL_W] = div_q;
        bus_rdata[CTL_EN]   = en_q;
        bus_rdata[CTL_GO]   = busy;
        bus_rdata[CTL_IE]   = ie_q;
        bus_rdata[CTL_FLAG] = flag_q;
        bus_rdata[CTL_AUTO] = auto_q;
      end
      ADDR_SEL: begin
        bus_rdata[SEL_CHAN_LSB +: CHAN_W] = pchan_q;
        bus_rdata[SEL_REF_LSB +: REF_W]   = pref_q;
        bus_rdata[SEL_LADJ] = ladj_q;
        bus_rdata[SEL_SRC]  = src_q;
      end
      ADDR_RES_L: bus_rdata = res_word[7:0];
      default:    bus_rdata = res_word[15:8];
    endcase
  end

  assign irq    = flag_q && ie_q && gie;
  assign chan_o = achan_q;
  assign ref_o  = aref_q;
  assign busy_o = busy;

  AST_FLAG_ON_DONE: assert property (@(posedge clk) disable iff (!rst_i)
    done |=> flag_q); // R7
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_i)
    busy && !done |=> $stable(achan_q) && $stable(aref_q)); // R9
endmodule

// File: tb/adcseq_ctrl_tb.sv
module adcseq_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       trig_in = 1'b0, gie = 1'b0, irq_ack = 1'b0;
  logic [9:0] sar_code = 10'd0;
  logic       irq, busy_o;
  logic [3:0] chan_o;
  logic [1:0] ref_o;

  int errors = 0, checks = 0;
  bit cmp_on = 1'b0, fin = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  adcseq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .trig_in(trig_in),
    .gie(gie), .irq_ack(irq_ack), .sar_code(sar_code), .irq(irq),
    .chan_o(chan_o), .ref_o(ref_o), .busy_o(busy_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model, advanced on each rising edge
  bit m_en, m_ie, m_auto, m_flag, m_src, m_ladj, m_busy, m_first, m_long, m_trigd;
  int m_divsel, m_pchan, m_pref, m_achan, m_aref, m_left, m_pc, m_res;

  function automatic int m_divisor(int s);
    return (s < 2) ? 2 : (1 << s);
  endfunction

  function automatic int m_read(int a);
    int w;
    w = m_ladj ? (m_res << 6) : m_res;
    case (a)
      0: return (int'(m_auto) << 7) | (int'(m_flag) << 6) | (int'(m_ie) << 5) |
                (int'(m_busy) << 4) | (int'(m_en) << 3) | m_divsel;
      1: return (int'(m_src) << 7) | (int'(m_ladj) << 6) | (m_pref << 4) | m_pchan;
      2: return w & 255;
      default: return (w >> 8) & 255;
    endcase
  endfunction

  task automatic m_step();
    bit wc, ws, en_n, rise, tick, edge_t, comp, ld, rdiff, lng, sw, hw, fr, go;
    wc     = bus_wr && bus_addr == 2'd0;
    ws     = bus_wr && bus_addr == 2'd1;
    en_n   = wc ? bus_wdata[3] : m_en;
    rise   = wc && bus_wdata[3] && !m_en;
    tick   = m_en && (m_pc >= m_divisor(m_divsel) - 1);
    edge_t = trig_in && !m_trigd;
    comp   = m_busy && tick && m_left == 1 && en_n;
    ld     = !m_busy || comp;
    rdiff  = ld && (m_pref != m_aref);
    lng    = m_first || rise || m_long || rdiff;
    sw     = wc && bus_wdata[4] && bus_wdata[3];
    hw     = m_en && m_auto && m_src && edge_t;
    fr     = comp && m_auto && !m_src;
    go     = (!m_busy && (sw || hw)) || fr;
    if (go) m_left = lng ? 25 : 13;
    else if (m_busy && tick) m_left = m_left - 1;
    if (comp) begin m_flag = 1; m_res = int'(sar_code); end
    else if (irq_ack || (wc && bus_wdata[6])) m_flag = 0;
    if (!en_n) m_first = 0; else if (go) m_first = 0; else if (rise) m_first = 1;
    if (go) m_long = 0; else if (rdiff) m_long = 1;
    if (ld) begin m_achan = m_pchan; m_aref = m_pref; end
    if (!m_en || tick) m_pc = 0; else m_pc = m_pc + 1;
    if (!en_n) m_busy = 0; else if (go) m_busy = 1; else if (comp) m_busy = 0;
    if (wc) begin
      m_en = bus_wdata[3]; m_ie = bus_wdata[5]; m_auto = bus_wdata[7];
      m_divsel = int'(bus_wdata[2:0]);
    end
    if (ws) begin
      m_src = bus_wdata[7]; m_ladj = bus_wdata[6];
      m_pref = int'(bus_wdata[5:4]); m_pchan = int'(bus_wdata[3:0]);
    end
    m_trigd = trig_in;
  endtask

  always @(posedge clk) begin
    if (cmp_on) begin
      m_step();
      #3;
      chk(busy_o == m_busy, "R4 busy vs model", busy_o, m_busy);
      chk(irq == (m_flag && m_ie && gie), "R8 irq vs model", irq, m_flag && m_ie && gie);
      chk(chan_o == m_achan[3:0] && ref_o == m_aref[1:0], "R9 applied select vs model",
          {ref_o, chan_o}, (m_aref << 4) | m_achan);
      chk(bus_rdata == m_read(bus_addr), "R10 read data vs model", bus_rdata, m_read(bus_addr));
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    step();
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a; #1; d = bus_rdata;
    step();
  endtask

  task automatic meas(output int n);
    n = 0;
    while (busy_o && n < 5000) begin n++; step(); end
  endtask

  initial begin
    #(4 * 200000);
    if (!fin) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int n;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) step();
    cmp_on = 1'b1;

    // reset state
    rd(2'd0, d); chk(d == 8'h00, "R4 control after reset", d, 0);
    rd(2'd2, d); chk(d == 8'h00, "R10 result low after reset", d, 0);
    chk(irq == 1'b0 && busy_o == 1'b0, "R8 idle outputs after reset", {irq, busy_o}, 0);

    // idle select write applies next cycle
    wr(2'd1, 8'h15); step();
    chk(chan_o == 4'd5 && ref_o == 2'd1, "R9 idle select applied", {ref_o, chan_o}, 8'h15);

    // enable+start together: exact long conversion at divide 2
    sar_code = 10'h2A5; gie = 1'b1;
    wr(2'd0, 8'h38); meas(n);
    chk(n == 50, "R2 R13 first conversion length div2", n, 50);
    rd(2'd0, d); chk(d == 8'h68, "R7 flag set after completion", d, 8'h68);
    chk(irq == 1'b1, "R8 irq with flag ie gie", irq, 1);
    rd(2'd2, d); chk(d == 8'hA5, "R10 right adjust low", d, 8'hA5);
    rd(2'd3, d); chk(d == 8'h02, "R10 right adjust high", d, 8'h02);
    wr(2'd1, 8'h55);
    rd(2'd3, d); chk(d == 8'hA9, "R10 left adjust high", d, 8'hA9);
    rd(2'd2, d); chk(d == 8'h40, "R10 left adjust low", d, 8'h40);

    // interrupt gating and write-one clear
    gie = 1'b0; step(); chk(irq == 1'b0, "R8 gie masks irq", irq, 0);
    gie = 1'b1; step(); chk(irq == 1'b1, "R8 gie unmasks irq", irq, 1);
    wr(2'd0, 8'h68); rd(2'd0, d);
    chk(d[6] == 1'b0 && irq == 1'b0, "R7 write one clears flag", d, 8'h28);

    // zero start bit does nothing; normal 13-cycle conversion at divide 8
    wr(2'd0, 8'h2B); step();
    chk(busy_o == 1'b0, "R4 zero start bit idle", busy_o, 0);
    wr(2'd0, 8'h3B); n = 0;
    repeat (10) begin if (busy_o) n++; step(); end
    if (busy_o) n++;
    wr(2'd0, 8'h2B);
    chk(busy_o == 1'b1, "R4 zero start bit while busy", busy_o, 1);
    begin int m; meas(m); n += m; end
    chk(n >= 97 && n <= 104, "R2 normal conversion length div8", n, 104);

    // deferred select, then long conversion after reference change
    sar_code = 10'h1C3;
    wr(2'd0, 8'h3B);
    wr(2'd1, 8'h69);
    chk(chan_o == 4'd5 && ref_o == 2'd1, "R9 select held during conversion", {ref_o, chan_o}, 8'h15);
    meas(n);
    chk(chan_o == 4'd9 && ref_o == 2'd2, "R9 select applied at completion", {ref_o, chan_o}, 8'h29);
    wr(2'd0, 8'h3B); meas(n);
    chk(n >= 193 && n <= 200, "R3 long after reference change", n, 200);

    // free running at divide 2
    wr(2'd1, 8'h09);
    wr(2'd0, 8'hB9);
    repeat (150) step();
    chk(busy_o == 1'b1, "R5 free running continues", busy_o, 1);
    sar_code = 10'h3FF;
    repeat (100) step();
    chk(busy_o == 1'b1, "R5 free running still busy", busy_o, 1);
    rd(2'd2, d); chk(d == 8'hFF, "R5 free running new result low", d, 8'hFF);
    rd(2'd3, d); chk(d == 8'h03, "R5 free running new result high", d, 8'h03);

    // abort
    wr(2'd0, 8'h00); chk(busy_o == 1'b0, "R6 disable stops free running", busy_o, 0);
    wr(2'd0, 8'h48);
    sar_code = 10'h155;
    wr(2'd0, 8'h18);
    repeat (10) step();
    wr(2'd0, 8'h00);
    chk(busy_o == 1'b0, "R6 abort clears busy", busy_o, 0);
    rd(2'd0, d); chk(d == 8'h00, "R6 abort leaves flag clear", d, 0);
    rd(2'd2, d); chk(d == 8'hFF, "R6 abort keeps result", d, 8'hFF);

    // external trigger at divide 4
    wr(2'd1, 8'h89);
    wr(2'd0, 8'hAA);
    repeat (5) step();
    chk(busy_o == 1'b0, "R11 no start without trigger", busy_o, 0);
    trig_in = 1'b1; step(); trig_in = 1'b0;
    chk(busy_o == 1'b1, "R11 trigger edge starts", busy_o, 1);
    n = 0;
    while (busy_o && n < 5000) begin
      n++;
      trig_in = (n == 20 || n == 21);
      step();
    end
    trig_in = 1'b0;
    n++;
    chk(n >= 97 && n <= 101, "R2 R11 triggered first conversion length", n, 100);
    repeat (10) step();
    chk(busy_o == 1'b0, "R12 trigger during busy dropped", busy_o, 0);
    chk(irq == 1'b1, "R8 irq after triggered conversion", irq, 1);
    irq_ack = 1'b1; step(); irq_ack = 1'b0;
    rd(2'd0, d); chk(d[6] == 1'b0, "R7 acknowledge clears flag", d, 8'hAA);

    // divide code 1 equals code 0, code 5 is 32
    wr(2'd0, 8'h00); wr(2'd1, 8'h09);
    wr(2'd0, 8'h19); meas(n);
    chk(n == 50, "R1 R13 divide code 1 gives 2", n, 50);
    wr(2'd0, 8'h00);
    wr(2'd0, 8'h1D); meas(n);
    chk(n == 800, "R1 R13 divide code 5 gives 32", n, 800);

    repeat (3) step();
    fin = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule